// File: doc/BRIEF.md
# Extended-Data-Out DRAM Access Sequencer

This block turns one host request at a time into the strobe and address sequence that an asynchronous extended-data-out DRAM expects. A request carries an operation code, a combined row/column address and write data. The sequencer puts the row half on the multiplexed address pins and lowers the row strobe. It then puts the column half on the pins and lowers the column strobe. Each step lasts a parameterized number of clock cycles.

Four operations are supported. A read lowers the output enable while the column strobe is low and captures the returned word. An early write lowers the write enable before the column strobe falls, so the device never drives its outputs. A late write keeps output enable high and lowers write enable only after the column strobe has fallen. A read-modify-write reads, raises output enable, then drives the new word and pulses write enable, all within one row strobe low period. It returns the old word to the host.

The controller drives the shared data bus only after the device has been unable to drive it for a set number of cycles. It releases the bus whenever output enable is low. When the part is built with output enable tied low, late-write and read-modify-write requests run as early writes.

Top module: `edo_dram_seq`

## Requirements
- R1: `req_ready` is high only while the sequencer is idle with all four strobes high. A request is taken on a clock edge where `req_valid` and `req_ready` are both high, and `req_ready` is low in the cycle after acceptance.
- R2: The row address (`req_addr` upper RA_W bits) is on `dram_addr` at least T_ASR cycles before `dram_ras_n` falls. The column address (lower CA_W bits) is on `dram_addr` at least T_ASC cycles before `dram_cas_n` falls. Each stays unchanged across its strobe edge.
- R3: `dram_cas_n` is high whenever `dram_ras_n` falls. Every request produces exactly one falling edge of `dram_ras_n`. Between requests both strobes are high for T_RP cycles.
- R4: Read (op 0) holds `dram_oe_n` low while `dram_cas_n` is low. `rsp_valid` pulses for one cycle exactly T_ASR+T_RAH+T_ASC+T_CAS clock edges after the accepting edge, and `rsp_rdata` then holds the stored word.
- R5: Early write (op 1) has `dram_we_n` low and the data bus driven when `dram_cas_n` falls, with `dram_oe_n` high, and stores `req_wdata`.
- R6: Late write (op 2) lowers `dram_we_n` only after `dram_cas_n` is low, keeps `dram_oe_n` high whenever `dram_we_n` is low, and stores `req_wdata`.
- R7: Read-modify-write (op 3) uses a single row strobe low period. It returns the previously stored word on `rsp_rdata` with the R4 latency, then writes `req_wdata` with a late write.
- R8: `dq_oe` is never high while the device may drive the bus (`dram_cas_n` low, `dram_oe_n` low, `dram_we_n` high). `dq_oe` is raised only after T_OFF cycles without such a state.
- R9: With OE_TIED clear, `dq_oe` is low in every cycle where `dram_oe_n` is low.
- R10: With OE_TIED set, `dram_oe_n` is constantly low. Ops 2 and 3 are carried out as early writes, and op 3 gives no `rsp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request accepted this edge if valid |
| req_op | input | 2 | 0 read, 1 early write, 2 late write, 3 read-modify-write |
| req_addr | input | RA_W+CA_W | Row in upper bits, column in lower bits |
| req_wdata | input | DW | Write data |
| rsp_valid | output | 1 | One-cycle read data strobe |
| rsp_rdata | output | DW | Captured read data |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_addr | output | max(RA_W,CA_W) | Multiplexed row/column address |
| dq_out | output | DW | Data toward the DRAM |
| dq_oe | output | 1 | Controller drives the data bus |
| dq_in | input | DW | Data from the DRAM |

## Verification
A read or read-modify-write response is due seven clock edges after the accepting edge with default timing. The bench records the accepting edge and compares the edge count when `rsp_valid` is seen, sampling on falling clock edges. Strobe ordering, address setup, bus contention and stored data are judged by a behavioural DRAM model. The model samples the strobes on every falling clock edge, so each strobe edge is seen in the cycle it occurs. Its event counters are compared before and after every request, and `req_ready` is checked one cycle after acceptance.

// File: rtl/edo_dram_seq.sv
module edo_dram_seq #(
  parameter int RA_W = 4,
  parameter int CA_W = 4,
  parameter int DW = 8,
  parameter int T_ASR = 1,
  parameter int T_RAH = 2,
  parameter int T_ASC = 1,
  parameter int T_CAS = 3,
  parameter int T_OFF = 2,
  parameter int T_WP = 2,
  parameter int T_RP = 3,
  parameter bit OE_TIED = 1'b0,
  localparam int AW = (RA_W > CA_W) ? RA_W : CA_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [1:0]           req_op,
  input  logic [RA_W+CA_W-1:0] req_addr,
  input  logic [DW-1:0]        req_wdata,
  output logic                 rsp_valid,
  output logic [DW-1:0]        rsp_rdata,
  output logic                 dram_ras_n,
  output logic                 dram_cas_n,
  output logic                 dram_we_n,
  output logic                 dram_oe_n,
  output logic [AW-1:0]        dram_addr,
  output logic [DW-1:0]        dq_out,
  output logic                 dq_oe,
  input  logic [DW-1:0]        dq_in
);
  localparam int CW = 8;
  localparam logic [1:0] OP_RD = 2'd0, OP_EW = 2'd1, OP_RMW = 2'd3;

  typedef enum logic [2:0] {S_IDLE, S_RSU, S_RHLD, S_CSU, S_CLOW, S_OEOFF, S_WR, S_PRE} st_t;
  st_t st, nx;

  logic [1:0]      op_q;
  logic [RA_W-1:0] row_q;
  logic [CA_W-1:0] col_q;
  logic [DW-1:0]   wd_q;
  logic [CW-1:0]   cnt, quiet;

  wire is_rd   = (op_q == OP_RD) || (op_q == OP_RMW);
  wire is_ew   = (op_q == OP_EW);
  wire oe_ok   = quiet >= CW'(T_OFF);
  wire done    = (cnt == '0);
  wire dev_drv = !dram_cas_n && !dram_oe_n && dram_we_n;
  wire capture = (st == S_CLOW) && done && is_rd;

  function automatic logic [CW-1:0] dur(input st_t s);
    case (s)
      S_RSU:   return CW'(T_ASR - 1);
      S_RHLD:  return CW'(T_RAH - 1);
      S_CSU:   return CW'(T_ASC - 1);
      S_CLOW:  return CW'(T_CAS - 1);
      S_WR:    return CW'(T_WP - 1);
      S_PRE:   return CW'(T_RP - 1);
      default: return '0;
    endcase
  endfunction

  always_comb begin
    nx = st;
    case (st)
      S_IDLE:  if (req_valid) nx = S_RSU;
      S_RSU:   if (done) nx = S_RHLD;
      S_RHLD:  if (done) nx = S_CSU;
      S_CSU:   if (done && (!is_ew || oe_ok)) nx = S_CLOW;
      S_CLOW:  if (done) nx = (is_ew || op_q == OP_RD) ? S_PRE : S_OEOFF;
      S_OEOFF: if (oe_ok) nx = S_WR;
      S_WR:    if (done) nx = S_PRE;
      S_PRE:   if (done) nx = S_IDLE;
      default: nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      quiet     <= '0;
      op_q      <= OP_RD;
      row_q     <= '0;
      col_q     <= '0;
      wd_q      <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      st        <= nx;
      cnt       <= (nx != st) ? dur(nx) : (done ? cnt : cnt - 1'b1);
      quiet     <= dev_drv ? '0 : ((quiet == '1) ? quiet : quiet + 1'b1);
      rsp_valid <= capture;
      if (capture) rsp_rdata <= dq_in;
      if (st == S_IDLE && req_valid) begin
        op_q  <= (OE_TIED && req_op[1]) ? OP_EW : req_op;
        row_q <= req_addr[RA_W+CA_W-1:CA_W];
        col_q <= req_addr[CA_W-1:0];
        wd_q  <= req_wdata;
      end
    end
  end

  wire col_phase = (st == S_CSU) || (st == S_CLOW) || (st == S_OEOFF) || (st == S_WR);

  assign req_ready  = (st == S_IDLE);
  assign dram_ras_n = (st == S_IDLE) || (st == S_RSU) || (st == S_PRE);
  assign dram_cas_n = !((st == S_CLOW) || (st == S_OEOFF) || (st == S_WR));
  assign dram_we_n  = !((is_ew && (st == S_CSU || st == S_CLOW)) || st == S_WR);
  assign dram_oe_n  = OE_TIED ? 1'b0 : !(is_rd && st == S_CLOW);
  assign dram_addr  = col_phase ? AW'(col_q) : AW'(row_q);
  assign dq_out     = wd_q;
  assign dq_oe      = (st == S_WR) || (is_ew && (st == S_CSU || st == S_CLOW) && oe_ok);
endmodule

module edo_dram_seq_chk #(
  parameter int AW = 4,
  parameter bit OE_TIED = 1'b0
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic          dram_ras_n,
  input logic          dram_cas_n,
  input logic          dram_we_n,
  input logic          dram_oe_n,
  input logic [AW-1:0] dram_addr,
  input logic          dq_oe
);
  a_r1_ready_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (dram_ras_n && dram_cas_n && dram_we_n));
  a_r2_row_stable: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dram_ras_n) |-> $stable(dram_addr));
  a_r2_col_stable: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dram_cas_n) |-> $stable(dram_addr));
  a_r3_cas_high_at_ras: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dram_ras_n) |-> dram_cas_n);
  a_r4_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  a_r8_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> !(!dram_cas_n && !dram_oe_n && dram_we_n));
  generate
    if (!OE_TIED) begin : g_oe
      a_r9_release_on_oe: assert property (@(posedge clk) disable iff (!rst_n)
        !dram_oe_n |-> !dq_oe);
      a_r6_oe_high_in_write: assert property (@(posedge clk) disable iff (!rst_n)
        !dram_we_n |-> dram_oe_n);
    end else begin : g_tied
      a_r10_oe_tied_low: assert property (@(posedge clk) disable iff (!rst_n)
        !dram_oe_n);
    end
  endgenerate
endmodule

bind edo_dram_seq edo_dram_seq_chk #(.AW(AW), .OE_TIED(OE_TIED)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
  .dram_oe_n(dram_oe_n), .dram_addr(dram_addr), .dq_oe(dq_oe));

// File: tb/edo_dram_seq_tb.sv
module edo_dram_seq_mem #(
  parameter int RA_W = 4,
  parameter int CA_W = 4,
  parameter int DW = 8,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          ras_n,
  input  logic          cas_n,
  input  logic          we_n,
  input  logic          oe_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] dq_out,
  input  logic          dq_oe,
  output logic [DW-1:0] dq_in
);
  logic [DW-1:0] mem [2**(RA_W+CA_W)];
  logic [RA_W-1:0] row;
  logic [CA_W-1:0] col;
  logic p_ras, p_cas, p_we;
  logic [AW-1:0] p_addr;
  int ras_cnt, early_cnt, late_cnt, err_rc, err_su, err_wd, err_ct;

  initial begin
    for (int i = 0; i < 2**(RA_W+CA_W); i++) mem[i] = DW'((i * 37 + 11) % 256);
    row = '0; col = '0; p_ras = 1; p_cas = 1; p_we = 1; p_addr = '0;
    ras_cnt = 0; early_cnt = 0; late_cnt = 0;
    err_rc = 0; err_su = 0; err_wd = 0; err_ct = 0;
  end

  assign dq_in = (!ras_n && !cas_n && !oe_n && we_n) ? mem[{row, col}] : DW'(8'hA5);

  always @(negedge clk) begin
    if (p_ras && !ras_n) begin
      ras_cnt++;
      row = addr[RA_W-1:0];
      if (!cas_n) err_rc++;
      if (addr != p_addr) err_su++;
    end
    if (p_cas && !cas_n) begin
      col = addr[CA_W-1:0];
      if (addr != p_addr) err_su++;
      if (!we_n) begin
        early_cnt++;
        if (!dq_oe) err_wd++;
        mem[{row, col}] = dq_out;
      end
    end else if (!p_cas && !cas_n && p_we && !we_n) begin
      late_cnt++;
      if (!dq_oe) err_wd++;
      mem[{row, col}] = dq_out;
    end
    if (dq_oe && !cas_n && !oe_n && we_n) err_ct++;
    p_ras = ras_n; p_cas = cas_n; p_we = we_n; p_addr = addr;
  end
endmodule

module edo_dram_seq_tb;
  localparam int RA_W = 4, CA_W = 4, DW = 8, AW = 4;
  localparam int LAT = 1 + 2 + 1 + 3;

  logic clk = 0, rst_n = 0;
  always #2.5 clk = ~clk;
  int cyc = 0;
  always @(posedge clk) cyc++;

  logic req_valid = 0;
  logic [1:0] req_op = 0;
  logic [7:0] req_addr = 0, req_wdata = 0;
  logic rdy_a, rv_a, ras_a, cas_a, we_a, oe_a, dqoe_a;
  logic rdy_b, rv_b, ras_b, cas_b, we_b, oe_b, dqoe_b;
  logic [DW-1:0] rd_a, rd_b, dqo_a, dqo_b, dqi_a, dqi_b;
  logic [AW-1:0] ad_a, ad_b;

  edo_dram_seq u_dut (.clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rdy_a),
    .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rv_a), .rsp_rdata(rd_a),
    .dram_ras_n(ras_a), .dram_cas_n(cas_a), .dram_we_n(we_a), .dram_oe_n(oe_a), .dram_addr(ad_a),
    .dq_out(dqo_a), .dq_oe(dqoe_a), .dq_in(dqi_a));
  edo_dram_seq #(.OE_TIED(1'b1)) u_dut_tied (.clk(clk), .rst_n(rst_n), .req_valid(req_valid),
    .req_ready(rdy_b), .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rv_b),
    .rsp_rdata(rd_b), .dram_ras_n(ras_b), .dram_cas_n(cas_b), .dram_we_n(we_b), .dram_oe_n(oe_b),
    .dram_addr(ad_b), .dq_out(dqo_b), .dq_oe(dqoe_b), .dq_in(dqi_b));
  edo_dram_seq_mem u_mem_a (.clk(clk), .ras_n(ras_a), .cas_n(cas_a), .we_n(we_a), .oe_n(oe_a),
    .addr(ad_a), .dq_out(dqo_a), .dq_oe(dqoe_a), .dq_in(dqi_a));
  edo_dram_seq_mem u_mem_b (.clk(clk), .ras_n(ras_b), .cas_n(cas_b), .we_n(we_b), .oe_n(oe_b),
    .addr(ad_b), .dq_out(dqo_b), .dq_oe(dqoe_b), .dq_in(dqi_b));

  int checks = 0, fails = 0;
  logic [7:0] refm [256];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_req(input logic [1:0] op, input logic [7:0] a, input logic [7:0] d);
    int ea, la, ra, eb, rb, acc, lat_a, guard;
    bit got_a, got_b;
    logic [7:0] expd, da;
    expd = refm[a];
    ea = u_mem_a.early_cnt; la = u_mem_a.late_cnt; ra = u_mem_a.ras_cnt;
    eb = u_mem_b.early_cnt; rb = u_mem_b.ras_cnt;
    got_a = 0; got_b = 0; lat_a = -1; da = 0; guard = 0;
    @(negedge clk);
    while (!(rdy_a && rdy_b)) @(negedge clk);
    req_valid = 1; req_op = op; req_addr = a; req_wdata = d;
    acc = cyc + 1;
    @(negedge clk);
    req_valid = 0;
    chk(!rdy_a && !rdy_b, "R1 busy after accept", {rdy_a, rdy_b}, 0);
    while (!(rdy_a && rdy_b) && guard < 200) begin
      if (rv_a) begin got_a = 1; lat_a = cyc - acc; da = rd_a; end
      if (rv_b) got_b = 1;
      guard++;
      @(negedge clk);
    end
    if (op != 2'd0) refm[a] = d;
    chk(u_mem_a.ras_cnt == ra + 1, op == 2'd3 ? "R7 single ras period" : "R3 one ras fall",
        u_mem_a.ras_cnt - ra, 1);
    chk(u_mem_b.ras_cnt == rb + 1, "R3 one ras fall tied", u_mem_b.ras_cnt - rb, 1);
    case (op)
      2'd0: begin
        chk(got_a && lat_a == LAT, "R4 read latency", lat_a, LAT);
        chk(da == expd, "R4 read data", da, expd);
        chk(got_b, "R4 read tied rsp", got_b, 1);
      end
      2'd1: begin
        chk(u_mem_a.early_cnt == ea + 1, "R5 early ordering", u_mem_a.early_cnt - ea, 1);
        chk(u_mem_a.mem[a] == d, "R5 stored", u_mem_a.mem[a], d);
      end
      2'd2: begin
        chk(u_mem_a.late_cnt == la + 1 && u_mem_a.early_cnt == ea, "R6 late ordering",
            u_mem_a.late_cnt - la, 1);
        chk(u_mem_a.mem[a] == d, "R6 stored", u_mem_a.mem[a], d);
        chk(u_mem_b.early_cnt == eb + 1, "R10 late as early", u_mem_b.early_cnt - eb, 1);
      end
      default: begin
        chk(got_a && lat_a == LAT, "R7 rmw latency", lat_a, LAT);
        chk(da == expd, "R7 rmw old data", da, expd);
        chk(u_mem_a.late_cnt == la + 1, "R7 rmw write phase", u_mem_a.late_cnt - la, 1);
        chk(u_mem_a.mem[a] == d, "R7 stored", u_mem_a.mem[a], d);
        chk(!got_b, "R10 no rsp on tied rmw", got_b, 0);
        chk(u_mem_b.early_cnt == eb + 1, "R10 rmw as early", u_mem_b.early_cnt - eb, 1);
      end
    endcase
    if (op != 2'd0) chk(u_mem_b.mem[a] == d, "R10 tied stored", u_mem_b.mem[a], d);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'h5eed);
    for (int i = 0; i < 256; i++) refm[i] = 8'((i * 37 + 11) % 256);
    repeat (3) @(negedge clk);
    chk(rdy_a && ras_a && cas_a && we_a && oe_a && !dqoe_a && !rv_a, "R1 reset idle",
        {rdy_a, ras_a, cas_a, we_a, oe_a, dqoe_a, rv_a}, 7'b1111100);
    chk(!oe_b, "R10 oe tied at reset", oe_b, 0);
    rst_n = 1;
    do_req(2'd0, 8'h00, 8'h00);
    do_req(2'd1, 8'hFF, 8'h3C);
    do_req(2'd0, 8'hFF, 8'h00);
    do_req(2'd2, 8'h00, 8'hFF);
    do_req(2'd0, 8'h00, 8'h00);
    do_req(2'd3, 8'h5A, 8'h81);
    do_req(2'd3, 8'h5A, 8'h7E);
    do_req(2'd0, 8'h5A, 8'h00);
    for (int n = 0; n < 60; n++) begin
      logic [1:0] op;
      logic [7:0] a, d;
      op = 2'($urandom);
      a = 8'($urandom % 16) | ((n % 3 == 0) ? 8'hF0 : 8'h00);
      d = 8'($urandom);
      do_req(op, a, d);
    end
    chk(u_mem_a.err_rc == 0 && u_mem_b.err_rc == 0, "R3 cas high at ras fall", u_mem_a.err_rc, 0);
    chk(u_mem_a.err_su == 0 && u_mem_b.err_su == 0, "R2 address setup", u_mem_a.err_su, 0);
    chk(u_mem_a.err_ct == 0 && u_mem_b.err_ct == 0, "R8 bus contention", u_mem_a.err_ct, 0);
    chk(u_mem_a.err_wd == 0 && u_mem_b.err_wd == 0, "R5 data driven at write", u_mem_a.err_wd, 0);
    chk(!oe_b, "R10 oe tied low at end", oe_b, 0);
    for (int i = 0; i < 256; i++)
      if (u_mem_a.mem[i] != refm[i]) chk(0, "R9 final memory image", u_mem_a.mem[i], refm[i]);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule